// File: doc/BRIEF.md
# Watchdog overflow reset controller

This block is the core of a watchdog timer. An 8-bit up-counter advances once for each `tick` pulse while the timer is enabled. A mode bit selects between two modes. In watchdog mode, an overflow is a fault. In interval mode, the counter just wraps.

On a watchdog-mode overflow the block does three things:
- It sets a sticky overflow flag.
- It clears its own control register. This stops the counter, which has wrapped to zero.
- If the reset enable is set, it drives a fixed-length pulse on `chip_rst`, together with a reset-type indication.

The reset/status register keeps its contents through the reset that the block itself produces. It returns to its initial value only on the external power-on reset or on entry to standby.

Software reaches three registers over a simple register bus. Reads are combinational from `addr`. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `wdt_ovf_ctrl`

## Requirements
- R1: After `por_n` is low, address 2 (status) reads 0x1F, address 0 (control) reads 0x00 and address 1 (counter) reads 0x00.
- R2: A cycle with `standby` high returns the status register to 0x1F by the next cycle. The counter and the control register keep their values.
- R3: The control register is at address 0. Bit 7 is the enable and bit 6 the mode (1 = watchdog, 0 = interval); bits 5..0 read 0. The counter is at address 1. It adds one per `tick` cycle while the enable is 1, and it holds while the enable is 0.
- R4: A tick at count 0xFF in watchdog mode wraps the counter to 0x00 and sets status bit 7 (the overflow flag). It also clears the control register to 0x00.
- R5: In interval mode, a tick at 0xFF wraps the counter to 0x00. It leaves the flag at 0 and the control register unchanged, and it produces no `chip_rst`, whatever the reset enable holds.
- R6: The flag clears only on a status write with bit 7 = 0 that comes after a status read which returned bit 7 = 1. A write of bit 7 = 0 without such a read, or any write of bit 7 = 1, leaves the flag set.
- R7: Status bit 6 is the reset enable and bit 5 the reset-type select. If bit 6 is 1 at a watchdog-mode overflow, `chip_rst` is high for exactly 4 cycles, starting the cycle after the overflow edge. During that time `rst_kind` equals bit 5.
- R8: If the reset enable is 0 at a watchdog-mode overflow, `chip_rst` stays low.
- R9: Status bits 4..0 always read 1, whatever value is written to them.
- R10: A watchdog overflow that starts a `chip_rst` pulse leaves the reset enable and type-select bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | External power-on reset, active low, asynchronous |
| standby | input | 1 | Standby entry; reinitialises the status register |
| tick | input | 1 | Count enable pulse from the prescaler |
| addr | input | 2 | Register address (0 control, 1 counter, 2 status) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| chip_rst | output | 1 | Internal chip reset pulse |
| rst_kind | output | 1 | Reset-type select captured at pulse start |

## Verification
Register reads are combinational. The bench therefore samples `rdata` in the same cycle as the read, one time unit after the falling edge at which it drives `addr`.

A write, a tick or an overflow is due in the register contents one edge later. The bench reads back only after that edge.

`chip_rst` rises at the first falling-edge sample after the edge that takes the overflow tick. A falling-edge monitor counts its high cycles and records `rst_kind` while it is high. The pulse length is then compared over a window much longer than the pulse.

The arming read of R6 and the clearing write occupy separate cycles. Control and counter reads never arm the flag clear.

// File: rtl/wdt_ovf_pkg.sv
package wdt_ovf_pkg;
    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_COUNT = 2'd1,
        A_STAT  = 2'd2
    } wdt_addr_e;

    localparam logic [7:0] STAT_INIT = 8'h1F;

    localparam int B_FLAG = 7;
    localparam int B_RSTE = 6;
    localparam int B_RSEL = 5;
    localparam int B_EN   = 7;
    localparam int B_MODE = 6;

    typedef struct packed {
        logic flag;
        logic armed;
        logic rste;
        logic rsel;
    } stat_t;

    typedef struct packed {
        logic en;
        logic wd_mode;
    } ctrl_t;
endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         run,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (ld) begin
            cnt_d = ld_val;
        end else if (run && tick) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = (cnt_q == ALL1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdt_status_reg.sv
module wdt_status_reg
    import wdt_ovf_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       standby,
    input  logic       wd_ovf,
    input  logic       rd_hit,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    output logic       flag,
    output logic       rste,
    output logic       rsel
);
    localparam stat_t S_INIT = '{flag: STAT_INIT[B_FLAG], armed: 1'b0,
                                 rste: STAT_INIT[B_RSTE], rsel: STAT_INIT[B_RSEL]};

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hit && st_q.flag) st_d.armed = 1'b1;
        if (wr_hit) begin
            st_d.rste = wdata[B_RSTE];
            st_d.rsel = wdata[B_RSEL];
            if (!wdata[B_FLAG] && st_q.armed) begin
                st_d.flag  = 1'b0;
                st_d.armed = 1'b0;
            end
        end
        if (wd_ovf)  st_d.flag = 1'b1;
        if (standby) st_d = S_INIT;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= S_INIT;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign rste = st_q.rste;
    assign rsel = st_q.rsel;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic fire,
    input  logic kind_in,
    output logic active,
    output logic kind
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] left;
        logic          kind;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (fire) begin
            p_d.left = LOAD;
            p_d.kind = kind_in;
        end else if (p_q.left != '0) begin
            p_d.left = p_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active = (p_q.left != '0);
    assign kind   = p_q.kind;
endmodule

// File: rtl/wdt_ovf_ctrl.sv
module wdt_ovf_ctrl
    import wdt_ovf_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       standby,
    input  logic       tick,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       chip_rst,
    output logic       rst_kind
);
    ctrl_t             ctrl_d, ctrl_q;
    logic [CNT_W-1:0]  cnt_val;
    logic              wrap, wd_ovf, iv_ovf, ld_cnt, cnt_hold;
    logic              ovf_flag, rst_en, rst_sel;

    assign ld_cnt   = wr_en && (addr == A_COUNT);
    assign cnt_hold = !ctrl_q.en && !ld_cnt;
    assign wd_ovf   = wrap && ctrl_q.wd_mode;
    assign iv_ovf   = wrap && !ctrl_q.wd_mode;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && addr == A_CTRL) begin
            ctrl_d.en      = wdata[B_EN];
            ctrl_d.wd_mode = wdata[B_MODE];
        end
        if (wd_ovf) ctrl_d = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    wdt_tick_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .por_n  (por_n),
        .run    (ctrl_q.en),
        .tick   (tick),
        .ld     (ld_cnt),
        .ld_val (wdata[CNT_W-1:0]),
        .cnt    (cnt_val),
        .wrap   (wrap)
    );

    wdt_status_reg u_stat (
        .clk     (clk),
        .por_n   (por_n),
        .standby (standby),
        .wd_ovf  (wd_ovf),
        .rd_hit  (rd_en && addr == A_STAT),
        .wr_hit  (wr_en && addr == A_STAT),
        .wdata   (wdata),
        .flag    (ovf_flag),
        .rste    (rst_en),
        .rsel    (rst_sel)
    );

    wdt_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .por_n   (por_n),
        .fire    (wd_ovf && rst_en),
        .kind_in (rst_sel),
        .active  (chip_rst),
        .kind    (rst_kind)
    );

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {ctrl_q.en, ctrl_q.wd_mode, 6'b0};
            A_COUNT: rdata = 8'(cnt_val);
            A_STAT:  rdata = {ovf_flag, rst_en, rst_sel, STAT_INIT[4:0]};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdt_ovf_ctrl_chk.sv
module wdt_ovf_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             standby,
    input logic             wd_ovf,
    input logic             iv_ovf,
    input logic             rst_en,
    input logic             flag,
    input logic             chip_rst,
    input logic             cnt_hold,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       addr,
    input logic [7:0]       rdata
);
    p_ones_r9: assert property (@(posedge clk) disable iff (!por_n)
        (addr == 2'd2) |-> (rdata[4:0] == 5'h1F));

    p_standby_init_r2: assert property (@(posedge clk) disable iff (!por_n)
        standby |=> (!flag && !rst_en));

    p_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
        cnt_hold |=> $stable(cnt));

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!por_n)
        (wd_ovf && !standby) |=> flag);

    p_interval_r5: assert property (@(posedge clk) disable iff (!por_n)
        (iv_ovf && !flag && !standby) |=> !flag);

    p_pulse_start_r7: assert property (@(posedge clk) disable iff (!por_n)
        (wd_ovf && rst_en) |=> chip_rst);

    p_no_pulse_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chip_rst) |-> $past(wd_ovf && rst_en));

    p_keep_rste_r10: assert property (@(posedge clk) disable iff (!por_n)
        (wd_ovf && rst_en && !standby) |=> rst_en);
endmodule

bind wdt_ovf_ctrl wdt_ovf_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .standby  (standby),
    .wd_ovf   (wd_ovf),
    .iv_ovf   (iv_ovf),
    .rst_en   (rst_en),
    .flag     (ovf_flag),
    .chip_rst (chip_rst),
    .cnt_hold (cnt_hold),
    .cnt      (cnt_val),
    .addr     (addr),
    .rdata    (rdata)
);

// File: tb/wdt_ovf_ctrl_test.sv
`timescale 1ns/1ps
module wdt_ovf_ctrl_test;
    logic       clk = 0;
    logic       por_n = 0;
    logic       standby = 0;
    logic       tick = 0;
    logic [1:0] addr = 0;
    logic       wr_en = 0;
    logic       rd_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       chip_rst, rst_kind;

    int checks = 0;
    int errors = 0;
    int rst_cycles = 0;
    logic kind_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdt_ovf_ctrl uut (
        .clk(clk), .por_n(por_n), .standby(standby), .tick(tick),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .chip_rst(chip_rst), .rst_kind(rst_kind)
    );

    always @(negedge clk) if (chip_rst) begin
        rst_cycles++;
        kind_seen = rst_kind;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1;
        end
        @(negedge clk);
        tick = 0;
    endtask

    // expected count after n ticks from v; wd: watchdog mode stops at wrap
    function automatic int model_cnt(int v, int n, bit wd, output bit ovf);
        int c = v;
        bit en = 1;
        ovf = 0;
        for (int i = 0; i < n; i++) begin
            if (en) begin
                c = (c + 1) % 256;
                if (c == 0 && wd) begin
                    en = 0;
                    ovf = 1;
                end
            end
        end
        return c;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int v, n, e;
        bit wd, eo;
        void'($urandom(32'd1234));
        #11 por_n = 1;

        // R1 reset values
        rd(2, d); check("R1 status", d, 8'h1F);
        rd(0, d); check("R1 ctrl", d, 8'h00);
        rd(1, d); check("R1 count", d, 8'h00);

        // R3 hold then count
        wr(1, 8'h05);
        ticks(3);
        rd(1, d); check("R3 hold", d, 8'h05);
        wr(0, 8'h80);
        ticks(3);
        rd(1, d); check("R3 count", d, 8'h08);
        rd(0, d); check("R3 ctrl read", d, 8'h80);

        // R5 interval wrap with reset enable set
        wr(2, 8'h40);
        wr(0, 8'h00);
        wr(1, 8'hFE);
        wr(0, 8'h80);
        rst_cycles = 0;
        ticks(3);
        rd(1, d); check("R5 wrap", d, 8'h01);
        rd(2, d); check("R5 flag", d, 8'h5F);
        rd(0, d); check("R5 ctrl", d, 8'h80);
        check("R5 no reset", rst_cycles, 0);

        // R4/R8 watchdog overflow, reset disabled
        wr(0, 8'h00);
        wr(2, 8'h00);
        wr(1, 8'hFF);
        wr(0, 8'hC0);
        rst_cycles = 0;
        ticks(1);
        rd(0, d); check("R4 ctrl cleared", d, 8'h00);
        rd(1, d); check("R4 count", d, 8'h00);
        check("R8 no reset", rst_cycles, 0);

        // R6 clear protocol
        wr(2, 8'h00);
        rd(2, d); check("R6 write0 without read", d, 8'h9F);
        wr(2, 8'h80);
        rd(2, d); check("R6 write1", d, 8'h9F);
        wr(2, 8'h00);
        rd(2, d); check("R6 cleared", d, 8'h1F);

        // R7/R10 reset pulse
        wr(2, 8'h60);
        rd(2, d); check("R9 low bits", d, 8'h7F);
        wr(1, 8'hFF);
        wr(0, 8'hC0);
        rst_cycles = 0;
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        check("R7 start", chip_rst, 1);
        repeat (10) @(negedge clk);
        check("R7 length", rst_cycles, 4);
        check("R7 kind", kind_seen, 1);
        rd(2, d); check("R10 status kept", d, 8'hFF);

        // R2 standby
        wr(1, 8'h33);
        wr(0, 8'h40);
        @(negedge clk); standby = 1;
        @(negedge clk); standby = 0;
        rd(2, d); check("R2 status init", d, 8'h1F);
        rd(1, d); check("R2 count kept", d, 8'h33);
        rd(0, d); check("R2 ctrl kept", d, 8'h40);

        // random rounds (R3, R4, R5)
        for (int r = 0; r < 40; r++) begin
            v = ($urandom % 2) ? 240 + $urandom % 16 : $urandom % 256;
            n = $urandom % 20;
            wd = $urandom % 2;
            wr(0, 8'h00);
            rd(2, d);
            wr(2, 8'h00);
            wr(1, 8'(v));
            wr(0, {1'b1, wd, 6'b0});
            if (n > 0) ticks(n);
            e = model_cnt(v, n, wd, eo);
            rd(1, d); check("R3 random count", d, e);
            rd(2, d); check(wd ? "R4 random flag" : "R5 random flag", d, {eo, 7'h1F});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule